// File: doc/BRIEF.md
# Toggle-Signalled Elastic Stage Buffer

This block sits between two pipeline stages that signal each transaction by a single change of level on a request wire (`in_go`, `out_go`) and answer with a single change of level on an acknowledge wire (`in_ack`, `out_ack`). There is no return-to-zero phase: a rising and a falling edge are both one complete transaction, and only a difference between the request level and the acknowledge level means a transaction is outstanding. The block is a clocked model of this exchange. Incoming level changes pass through a synchroniser. Each detected event is written into a small first-in first-out store and answered on `in_ack`. Stored words are then offered one at a time to the next stage by toggling `out_go`.

The store lets the upstream stage keep delivering words while the downstream stage is slow or stalled. Only when all `DEPTH` entries are occupied does the buffer withhold `in_ack`. Once an entry is released, the pending event is accepted without the sender doing anything further.

The receive side is a two-state machine. RX_IDLE moves to RX_HELD when an event is waiting and the store is full, and RX_HELD returns to RX_IDLE when space appears. The send side is also a two-state machine. TX_IDLE moves to TX_WAIT when the store holds a word, toggling `out_go`. TX_WAIT returns to TX_IDLE when the synchronised `out_ack` equals `out_go`, and that same step removes the head word.

Top module: `toggle_link_queue`

## Requirements
- R1: While `rst_n` is low, and after it is released with no input activity, `in_ack` and `out_go` are 0 and the store is empty.
- R2: A change of `in_go` in either direction, with space in the store, produces exactly one change of `in_ack`, so that `in_ack` again equals `in_go`. The change appears on the SYNC_STAGES+1-th rising edge after the change of `in_go`.
- R3: While `in_go` holds its level, `in_ack` does not change.
- R4: The block accepts `DEPTH` words with the downstream stage stalled. A further event gets no `in_ack` change until the downstream stage acknowledges a word, after which the waiting event is accepted with no new `in_go` change.
- R5: `out_go` changes only when `out_go` equals `out_ack`, which means no word is outstanding. When a word is accepted into an empty idle buffer, `out_go` changes on the next rising edge.
- R6: `out_data` carries the offered word and holds it unchanged from the edge on which `out_go` changes until `out_ack` matches `out_go`.
- R7: Words leave in the order they arrived.
- R8: When the store is empty, `out_go` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_go | input | 1 | Upstream request; each level change is one transaction |
| in_data | input | DATA_W | Upstream word, stable from before the `in_go` change until `in_ack` matches |
| in_ack | output | 1 | Acknowledge to upstream; one level change per accepted word |
| out_go | output | 1 | Request to downstream; one level change per offered word |
| out_data | output | DATA_W | Offered word |
| out_ack | input | 1 | Downstream acknowledge; one level change per taken word |

## Verification
The bench builds the block with DATA_W=8, DEPTH=4 and SYNC_STAGES=2. A depth of four makes the full condition reachable after only a few transfers. Two synchroniser flops give a three-edge acknowledge latency that the bench checks edge by edge. With these values the bench covers level changes in both directions, the withheld acknowledge with its release, and a concurrent stream in which producer and consumer run at different rates.

// File: rtl/tlq_pkg.sv
package tlq_pkg;
    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_HELD = 1'b1
    } rx_state_t;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_t;
endpackage

// File: rtl/tlq_sync.sv
module tlq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    for (genvar i = 0; i < STAGES; i++) begin : g_ff
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[0] <= 1'b0;
                else        sr[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[i] <= 1'b0;
                else        sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/tlq_store.sv
module tlq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_en,
    output logic [DATA_W-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        full,
    output logic                        empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  fill;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) slot[tail] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            fill <= '0;
        end else begin
            if (wr_en) tail <= step(tail);
            if (rd_en) head <= step(head);
            unique case ({wr_en, rd_en})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign rd_data = slot[head];
    assign count   = fill;
    assign full    = (fill == FULL_CNT);
    assign empty   = (fill == '0);
endmodule

// File: rtl/tlq_rx.sv
module tlq_rx
    import tlq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_seen,
    input  logic      full,
    output logic      ack,
    output logic      wr_en,
    output rx_state_t state
);
    rx_state_t state_q, state_d;
    logic      ack_q;
    logic      pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ack_q <= 1'b0;
        else if (wr_en) ack_q <= go_seen;
    end

    always_comb begin
        pending = (go_seen != ack_q);
        wr_en   = pending && !full;
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (pending && full) state_d = RX_HELD;
            RX_HELD: if (!full)           state_d = RX_IDLE;
            default:                      state_d = RX_IDLE;
        endcase
    end

    assign ack   = ack_q;
    assign state = state_q;
endmodule

// File: rtl/tlq_tx.sv
module tlq_tx
    import tlq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_seen,
    input  logic      empty,
    output logic      go,
    output logic      rd_en,
    output tx_state_t state
);
    tx_state_t state_q, state_d;
    logic      go_q;
    logic      launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      go_q <= 1'b0;
        else if (launch) go_q <= ~go_q;
    end

    always_comb begin
        launch  = 1'b0;
        rd_en   = 1'b0;
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (!empty) begin
                launch  = 1'b1;
                state_d = TX_WAIT;
            end
            TX_WAIT: if (ack_seen == go_q) begin
                rd_en   = 1'b1;
                state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    assign go    = go_q;
    assign state = state_q;
endmodule

// File: rtl/toggle_link_queue.sv
module toggle_link_queue
    import tlq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_go,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ack,
    output logic              out_go,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ack
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             go_seen, ack_seen;
    logic             wr_en, rd_en, full, empty;
    logic [CNT_W-1:0] level_cnt;
    rx_state_t        rx_state;
    tx_state_t        tx_state;

    tlq_sync #(.STAGES(SYNC_STAGES)) u_sync_go (
        .clk(clk), .rst_n(rst_n), .d(in_go), .q(go_seen)
    );

    tlq_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d(out_ack), .q(ack_seen)
    );

    tlq_rx u_rx (
        .clk(clk), .rst_n(rst_n), .go_seen(go_seen), .full(full),
        .ack(in_ack), .wr_en(wr_en), .state(rx_state)
    );

    tlq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(in_data),
        .rd_en(rd_en), .rd_data(out_data),
        .count(level_cnt), .full(full), .empty(empty)
    );

    tlq_tx u_tx (
        .clk(clk), .rst_n(rst_n), .ack_seen(ack_seen), .empty(empty),
        .go(out_go), .rd_en(rd_en), .state(tx_state)
    );
endmodule

// File: rtl/toggle_link_queue_chk.sv
module toggle_link_queue_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_go,
    input logic                       in_ack,
    input logic                       out_go,
    input logic                       out_ack,
    input logic [DATA_W-1:0]          out_data,
    input logic [$clog2(DEPTH+1)-1:0] level_cnt
);
    assert_ack_answers_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_ack) |-> $past(in_go != in_ack));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    assert_go_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_go) |-> $past(out_go == out_ack));

    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_go != out_ack) |-> $stable(out_data));

    assert_quiet_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_cnt == '0) |=> $stable(out_go));
endmodule

bind toggle_link_queue toggle_link_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_go(in_go), .in_ack(in_ack),
    .out_go(out_go), .out_ack(out_ack), .out_data(out_data), .level_cnt(level_cnt)
);

// File: tb/toggle_link_queue_tb.sv
module toggle_link_queue_tb;
    localparam int DW = 8, DEPTH = 4, SYNC = 2;
    localparam int ACK_LAT = SYNC + 1;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          in_go = 1'b0, out_ack = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ack, out_go;
    logic [DW-1:0] out_data;
    logic [DW-1:0] model[$];
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    toggle_link_queue #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_go(in_go), .in_data(in_data), .in_ack(in_ack),
        .out_go(out_go), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [DW-1:0] d, input string tag);
        int w = 0;
        while (in_go != in_ack && w < 60) begin tick(1); w++; end
        in_data = d;
        tick(1);
        model.push_back(d);
        in_go = ~in_go;
        w = 0;
        while (in_ack != in_go && w < 60) begin tick(1); w++; end
        check(in_ack == in_go, tag, in_ack, in_go);
    endtask

    task automatic take_word(input string tag);
        int w = 0;
        logic [DW-1:0] e;
        while (out_go == out_ack && w < 80) begin tick(1); w++; end
        e = (model.size() > 0) ? model.pop_front() : 'x;
        check(out_go != out_ack && out_data === e, tag, out_data, e);
        out_ack = out_go;
    endtask

    task automatic t_reset();
        check(in_ack == 1'b0 && out_go == 1'b0, "R1 during reset", {in_ack, out_go}, 0);
        tick(2);
        rst_n = 1'b1;
        tick(8);
        check(in_ack == 1'b0 && out_go == 1'b0, "R1 after release", {in_ack, out_go}, 0);
    endtask

    task automatic t_latency();
        logic a0 = in_ack, g0 = out_go;
        in_data = 8'hA5;
        tick(1);
        model.push_back(8'hA5);
        in_go = ~in_go;
        for (int k = 1; k <= ACK_LAT; k++) begin
            tick(1);
            if (k < ACK_LAT) check(in_ack == a0, "R2 ack not early", in_ack, a0);
            else             check(in_ack == in_go, "R2 ack on time", in_ack, in_go);
        end
        tick(1);
        check(out_go == ~g0, "R5 out_go next edge", out_go, ~g0);
        take_word("R6 R7 first word");
        tick(12);
        check(out_go == g0 ^ 1'b1 && out_go == out_ack, "R8 idle when empty", out_go, out_ack);
        a0 = in_ack;
        tick(15);
        check(in_ack == a0, "R3 no event no ack", in_ack, a0);
    endtask

    task automatic t_level();
        push_word(8'h3C, "R2 second toggle");
        check(in_ack == 1'b0, "R2 falling go counts", in_ack, 0);
        take_word("R7 falling word");
        tick(10);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push_word(8'h10 + 8'(i), "R4 accept while stalled");
        in_data = 8'h99;
        tick(1);
        model.push_back(8'h99);
        in_go = ~in_go;
        tick(20);
        check(in_ack != in_go, "R4 ack withheld when full", in_ack, ~in_go);
        check(out_data == 8'h10 && out_go != out_ack, "R6 data held while pending", out_data, 8'h10);
        take_word("R7 head of full");
        tick(20);
        check(in_ack == in_go, "R4 waiting event accepted", in_ack, in_go);
        for (int i = 0; i < DEPTH; i++) take_word("R7 drain order");
        check(model.size() == 0, "R7 all drained", model.size(), 0);
        tick(10);
        check(out_go == out_ack, "R8 no offer when empty", out_go, out_ack);
    endtask

    task automatic t_stream();
        fork
            begin
                for (int i = 0; i < 12; i++) begin
                    push_word(8'hC0 + 8'(i * 7), "R2 stream accept");
                    tick(i % 2);
                end
            end
            begin
                for (int i = 0; i < 12; i++) begin
                    tick(i % 4);
                    take_word("R7 stream order");
                end
            end
        join
        tick(10);
        check(model.size() == 0 && out_go == out_ack, "R8 stream ends empty", model.size(), 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_level();
        t_full();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule